// File: doc/BRIEF.md
# Serial ADC Output Interface Emulator

This block reproduces, in synthesizable logic, the digital side of a three-wire serial analog-to-digital converter. A parallel input stands in for the analog core. It carries a signed level that is clamped to a 16-bit straight-binary code. A host drives an active-low select and a serial clock, both asynchronous to the block. The block oversamples both with its own faster system clock through three-flop synchronizers with edge detection.

A select falling edge captures the code and starts a frame. The frame FSM counts serial-clock falling edges:

- `FR_IDLE` goes to `FR_LEAD` on a select fall.
- `FR_LEAD` goes to `FR_ZERO` on the fifth fall.
- `FR_ZERO` goes to `FR_DATA` on the sixth fall.
- `FR_DATA` goes to `FR_TAIL` on the twenty-second fall.
- `FR_TAIL` holds, with its counter saturated.
- Every state goes back to `FR_IDLE` when select rises, which also aborts an unfinished frame.

In `FR_LEAD` and `FR_IDLE` the output enable is low. In `FR_ZERO` and `FR_TAIL` the line is driven low. In `FR_DATA` it carries the captured code, MSB first.

A second FSM runs the conversion indicator:

- `CV_SLEEP` (power-down) goes to `CV_CONV` (busy) on a select fall.
- `CV_CONV` goes back to `CV_SLEEP` after a fixed number of system clocks.
- The block then stays in power-down until the next select fall.

Data output and enable are separate ports. The pad tristate is left to the level above.

Top module: `adc_serial_emu`

## Requirements
- R1: The code shifted out in a frame is the clamped level present when select fell. Changes to `level_i` after the capture do not alter that frame.
- R2: Once `csn_i` has been high for three system clocks, `sdo_oe_o` is 0 and stays 0 while `csn_i` stays high.
- R3: On falls 1 to 4 of `sclk_i` after select falls, `sdo_oe_o` stays 0. On fall 5, `sdo_oe_o` becomes 1 with `sdo_o` = 0.
- R4: Falls 6 to 21 present code bits 15 down to 0, one bit per fall, with `sdo_oe_o` = 1.
- R5: From fall 22 on, `sdo_o` = 0 with `sdo_oe_o` = 1 until select rises. Further falls change nothing.
- R6: `busy_o` is 1 (with `pwrdn_o` = 0) for exactly CONV_CYCLES system clocks, starting three clocks after select falls. After that, `pwrdn_o` = 1 and `busy_o` = 0 until the next select fall.
- R7: A negative level gives code 0x0000. A level above 65535 gives 0xFFFF. Levels from 0 to 65535 pass unchanged.
- R8: A select rise before fall 22 aborts the frame. The next frame starts again with four undriven falls.
- R9: After reset, `sdo_oe_o` = 0, `sdo_o` = 0, `busy_o` = 0 and `pwrdn_o` = 1.
- R10: Serial-clock falls while select is high are ignored. The next frame still needs five falls before the line is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level_i | input | 18 | Signed stand-in for the analog level |
| csn_i | input | 1 | Active-low select, asynchronous |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| sdo_o | output | 1 | Serial data value |
| sdo_oe_o | output | 1 | Serial data output enable (0 means high impedance) |
| busy_o | output | 1 | Conversion in progress |
| pwrdn_o | output | 1 | Power-down state indicator |

## Verification
Frames are run with several code patterns:

- Alternating patterns (0xA5C3, 0x5555) expose bit-order and shift-alignment errors.
- Codes with a single bit differing at the top (0x8000, 0x7FFF) expose an MSB/LSB swap or an off-by-one in the leading count.
- The all-ones and all-zeros codes separate the data phase from the driven-low phases around it.

Negative, overrange and exact-full-scale levels tell the clamp boundaries apart. Changing the level after capture separates a frame-start capture from a pipelined or transparent one. An aborted frame and stray serial-clock falls while deselected show whether the fall counter really returns to idle.

// File: rtl/adc_emu_pkg.sv
package adc_emu_pkg;

    typedef enum logic [2:0] {
        FR_IDLE,
        FR_LEAD,
        FR_ZERO,
        FR_DATA,
        FR_TAIL
    } frame_state_t;

    typedef enum logic {
        CV_SLEEP,
        CV_CONV
    } conv_state_t;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
    parameter int            N       = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] edge_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        // pipe[0], pipe[1]: synchronizer; pipe[2]: previous value for edge detection
        logic [2:0] pipe;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= {3{RST_VAL[g]}};
            else        pipe <= {pipe[1:0], async_i[g]};
        end

        assign lvl_o[g]  = pipe[1];
        assign edge_o[g] = pipe[2] ^ pipe[1];
    end

endmodule

// File: rtl/adc_code_clamp.sv
module adc_code_clamp #(
    parameter int IN_W   = 18,
    parameter int CODE_W = 16
) (
    input  logic signed [IN_W-1:0] level_i,
    output logic [CODE_W-1:0]      code_o
);

    logic neg;
    logic over;

    assign neg  = level_i[IN_W-1];
    assign over = !neg && (|level_i[IN_W-2:CODE_W]);

    always_comb begin
        if (neg)       code_o = '0;
        else if (over) code_o = '1;
        else           code_o = level_i[CODE_W-1:0];
    end

endmodule

// File: rtl/adc_frame_fsm.sv
module adc_frame_fsm
    import adc_emu_pkg::*;
#(
    parameter int CODE_W     = 16,
    parameter int LEAD_FALLS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              desel_i,
    input  logic              sclk_fall_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              sdo_o,
    output logic              oe_o
);

    localparam int TOTAL_FALLS = LEAD_FALLS + CODE_W + 1;
    localparam int CNT_W       = $clog2(TOTAL_FALLS + 1);

    frame_state_t      state, state_nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic [CODE_W-1:0] shreg, shreg_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= FR_IDLE;
            cnt   <= '0;
            shreg <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            shreg <= shreg_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        shreg_nxt = shreg;
        if (desel_i) begin
            state_nxt = FR_IDLE;
            cnt_nxt   = '0;
        end else begin
            unique case (state)
                FR_IDLE: begin
                    if (start_i) begin
                        state_nxt = FR_LEAD;
                        cnt_nxt   = '0;
                        shreg_nxt = code_i;
                    end
                end
                FR_LEAD: begin
                    if (sclk_fall_i) begin
                        cnt_nxt = cnt + 1'b1;
                        if (cnt_nxt == CNT_W'(LEAD_FALLS)) state_nxt = FR_ZERO;
                    end
                end
                FR_ZERO: begin
                    if (sclk_fall_i) begin
                        cnt_nxt   = cnt + 1'b1;
                        state_nxt = FR_DATA;
                    end
                end
                FR_DATA: begin
                    if (sclk_fall_i) begin
                        cnt_nxt = cnt + 1'b1;
                        if (cnt_nxt == CNT_W'(TOTAL_FALLS)) state_nxt = FR_TAIL;
                        else                                shreg_nxt = shreg << 1;
                    end
                end
                FR_TAIL: begin
                    cnt_nxt = cnt;
                end
                default: begin
                    state_nxt = FR_IDLE;
                    cnt_nxt   = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state)
            FR_IDLE, FR_LEAD: begin
                oe_o  = 1'b0;
                sdo_o = 1'b0;
            end
            FR_ZERO, FR_TAIL: begin
                oe_o  = 1'b1;
                sdo_o = 1'b0;
            end
            FR_DATA: begin
                oe_o  = 1'b1;
                sdo_o = shreg[CODE_W-1];
            end
            default: begin
                oe_o  = 1'b0;
                sdo_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_emu_pkg::*;
#(
    parameter int CONV_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic pwrdn_o
);

    localparam int CW = $clog2(CONV_CYCLES + 1);

    conv_state_t   state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CV_SLEEP;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        if (start_i) begin
            state_nxt = CV_CONV;
            cnt_nxt   = CW'(CONV_CYCLES - 1);
        end else begin
            unique case (state)
                CV_SLEEP: cnt_nxt = '0;
                CV_CONV: begin
                    if (cnt == '0) state_nxt = CV_SLEEP;
                    else           cnt_nxt   = cnt - 1'b1;
                end
                default: state_nxt = CV_SLEEP;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            CV_CONV: begin
                busy_o  = 1'b1;
                pwrdn_o = 1'b0;
            end
            default: begin
                busy_o  = 1'b0;
                pwrdn_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/adc_serial_emu.sv
module adc_serial_emu #(
    parameter int CODE_W      = 16,
    parameter int IN_W        = 18,
    parameter int LEAD_FALLS  = 5,
    parameter int CONV_CYCLES = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic signed [IN_W-1:0] level_i,
    input  logic                   csn_i,
    input  logic                   sclk_i,
    output logic                   sdo_o,
    output logic                   sdo_oe_o,
    output logic                   busy_o,
    output logic                   pwrdn_o
);

    // bit 0: select (idles high), bit 1: serial clock (idles low)
    logic [1:0]        s_lvl;
    logic [1:0]        s_edge;
    logic [CODE_W-1:0] code;
    logic              cs_start;
    logic              cs_desel;
    logic              sclk_fall;

    adc_edge_sync #(
        .N       (2),
        .RST_VAL (2'b01)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({sclk_i, csn_i}),
        .lvl_o   (s_lvl),
        .edge_o  (s_edge)
    );

    assign cs_start  = s_edge[0] & ~s_lvl[0];
    assign cs_desel  = s_lvl[0];
    assign sclk_fall = s_edge[1] & ~s_lvl[1];

    adc_code_clamp #(
        .IN_W   (IN_W),
        .CODE_W (CODE_W)
    ) u_clamp (
        .level_i (level_i),
        .code_o  (code)
    );

    adc_frame_fsm #(
        .CODE_W     (CODE_W),
        .LEAD_FALLS (LEAD_FALLS)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (cs_start),
        .desel_i     (cs_desel),
        .sclk_fall_i (sclk_fall),
        .code_i      (code),
        .sdo_o       (sdo_o),
        .oe_o        (sdo_oe_o)
    );

    adc_conv_timer #(
        .CONV_CYCLES (CONV_CYCLES)
    ) u_conv (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (cs_start),
        .busy_o  (busy_o),
        .pwrdn_o (pwrdn_o)
    );

endmodule

// File: rtl/adc_serial_emu_chk.sv
module adc_serial_emu_chk #(
    parameter int CONV_CYCLES = 32
) (
    input logic clk,
    input logic rst_n,
    input logic csn_i,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic busy_o
);

    localparam int BW = $clog2(CONV_CYCLES + 2) + 1;

    logic [BW-1:0] busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      busy_len <= '0;
        else if (busy_o) busy_len <= busy_len + 1'b1;
        else             busy_len <= '0;
    end

    AST_HIZ_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (csn_i && $past(csn_i) && $past(csn_i, 2) && $past(csn_i, 3)) |-> !sdo_oe_o); // R2

    AST_ENABLE_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sdo_o); // R3

    AST_BUSY_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(csn_i, 4) && !$past(csn_i, 3))); // R6

    AST_BUSY_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_len < BW'(CONV_CYCLES))); // R6

endmodule

bind adc_serial_emu adc_serial_emu_chk #(
    .CONV_CYCLES (CONV_CYCLES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .csn_i    (csn_i),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .busy_o   (busy_o)
);

// File: tb/adc_serial_emu_test.sv
module adc_serial_emu_test;

    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 16;
    localparam int IN_W       = 18;
    localparam int LEAD       = 5;
    localparam int CONV       = 32;
    localparam int HALF       = 8;

    logic                   clk;
    logic                   rst_n;
    logic signed [IN_W-1:0] level_i;
    logic                   csn_i;
    logic                   sclk_i;
    logic                   sdo_o;
    logic                   sdo_oe_o;
    logic                   busy_o;
    logic                   pwrdn_o;

    adc_serial_emu #(
        .CODE_W      (CODE_W),
        .IN_W        (IN_W),
        .LEAD_FALLS  (LEAD),
        .CONV_CYCLES (CONV)
    ) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_i  (level_i),
        .csn_i    (csn_i),
        .sclk_i   (sclk_i),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o),
        .busy_o   (busy_o),
        .pwrdn_o  (pwrdn_o)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    typedef struct {
        logic  oe;
        logic  sdo;
        string tag;
    } exp_t;

    exp_t q[$];
    event sample_ev;
    int   n_chk  = 0;
    int   n_fail = 0;

    task automatic check_bit(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [CODE_W-1:0] clamp_ref(input int lvl);
        if (lvl < 0)          return '0;
        else if (lvl > 65535) return '1;
        else                  return lvl[CODE_W-1:0];
    endfunction

    // monitor: pops one expected item per serial-clock fall and compares
    initial begin
        forever begin
            @(sample_ev);
            if (q.size() == 0) begin
                check_bit("scoreboard underflow", 1'b1, 1'b0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check_bit({e.tag, " oe"}, sdo_oe_o, e.oe);
                check_bit({e.tag, " sdo"}, sdo_o, e.sdo);
            end
        end
    end

    task automatic push_exp(input logic oe, input logic sdo, input string tag);
        exp_t e;
        e.oe  = oe;
        e.sdo = sdo;
        e.tag = tag;
        q.push_back(e);
    endtask

    task automatic sclk_pulse_expect(input logic oe, input logic sdo, input string tag);
        sclk_i = 1'b1;
        wait_cyc(HALF);
        sclk_i = 1'b0;
        wait_cyc(3);
        push_exp(oe, sdo, tag);
        -> sample_ev;
        wait_cyc(HALF);
    endtask

    task automatic run_frame(input int lvl, input int nfalls, input int lvl_after,
                             input string pre);
        logic [CODE_W-1:0] code;
        code    = clamp_ref(lvl);
        level_i = IN_W'(lvl);
        csn_i   = 1'b0;
        wait_cyc(3);
        check_bit({pre, " R6 busy after select fall"}, busy_o, 1'b1);
        check_bit({pre, " R6 pwrdn after select fall"}, pwrdn_o, 1'b0);
        level_i = IN_W'(lvl_after);
        wait_cyc(CONV - 1);
        check_bit({pre, " R6 busy last cycle"}, busy_o, 1'b1);
        wait_cyc(1);
        check_bit({pre, " R6 busy ended"}, busy_o, 1'b0);
        check_bit({pre, " R6 pwrdn entered"}, pwrdn_o, 1'b1);
        for (int i = 1; i <= nfalls; i++) begin
            if (i < LEAD)
                sclk_pulse_expect(1'b0, 1'b0, $sformatf("%s R3 lead fall %0d", pre, i));
            else if (i == LEAD)
                sclk_pulse_expect(1'b1, 1'b0, $sformatf("%s R3 fifth fall", pre));
            else if (i <= LEAD + CODE_W)
                sclk_pulse_expect(1'b1, code[CODE_W - 1 - (i - LEAD - 1)],
                                  $sformatf("%s R1/R4 bit %0d", pre, CODE_W - 1 - (i - LEAD - 1)));
            else
                sclk_pulse_expect(1'b1, 1'b0, $sformatf("%s R5 tail fall %0d", pre, i));
        end
        check_bit({pre, " R6 pwrdn held"}, pwrdn_o, 1'b1);
        csn_i = 1'b1;
        wait_cyc(4);
        check_bit({pre, " R2 oe after deselect"}, sdo_oe_o, 1'b0);
        check_bit({pre, " R2 sdo after deselect"}, sdo_o, 1'b0);
        wait_cyc(4);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        rst_n   = 1'b0;
        csn_i   = 1'b1;
        sclk_i  = 1'b0;
        level_i = '0;
        wait_cyc(5);
        check_bit("R9 reset oe", sdo_oe_o, 1'b0);
        check_bit("R9 reset sdo", sdo_o, 1'b0);
        check_bit("R9 reset busy", busy_o, 1'b0);
        check_bit("R9 reset pwrdn", pwrdn_o, 1'b1);
        rst_n = 1'b1;
        wait_cyc(3);

        run_frame(16'hA5C3, 24, 16'h1234, "pattern A5C3");
        run_frame(16'h8000, 22, 16'h7FFF, "pattern 8000");
        run_frame(16'h7FFF, 22, 16'h8000, "pattern 7FFF");
        run_frame(16'hFFFF, 23, 0, "pattern FFFF");
        run_frame(0, 22, 65535, "pattern 0000");

        // R7 clamping
        run_frame(-5, 22, 100, "R7 negative");
        run_frame(70000, 22, 0, "R7 overrange");
        run_frame(65535, 22, -1, "R7 full scale");

        // R8 abort then fresh frame
        run_frame(16'h5555, 10, 16'h5555, "R8 aborted");
        run_frame(16'hC00F, 26, 16'h0000, "R8 after abort");

        // R10 stray serial clock falls while deselected
        for (int k = 0; k < 3; k++) begin
            sclk_i = 1'b1;
            wait_cyc(HALF);
            sclk_i = 1'b0;
            wait_cyc(HALF);
            check_bit("R10 stray fall oe", sdo_oe_o, 1'b0);
            check_bit("R10 stray fall pwrdn", pwrdn_o, 1'b1);
        end
        run_frame(16'h3C3C, 22, 16'hFFFF, "R10 after stray");

        wait_cyc(4);
        finish_run();
    end

endmodule